// File: doc/BRIEF.md
# Configuration Frame Address Sequencer

This block produces, in a fixed order, every configuration frame address of a programmable fabric that is organised in columns. Each address is a triple: a frame type, a major number that selects a column, and a minor number that selects a frame within that column. A single start pulse begins a walk. From then on the current address is presented with a valid flag, and it moves to the next address each time the consumer accepts it with ready. Readback or write logic further down the chain uses the address and the frame count of the current column to fetch or store frame data. This block moves no frame data itself.

The walk covers three frame types in turn. Type 0 is the main area. It visits the clock spine, the left I/O buffer column, the left I/O interface column, each logic column from left to right, the right I/O interface column and finally the right I/O buffer column. Type 1 holds the block-memory contents, one column per block-memory column. Type 2 holds the block-memory routing, again one column per block-memory column. The major number restarts at zero for each type. The number of logic columns and the number of block-memory columns are parameters.

Top module: `frame_addr_seq`

## Requirements
- R1: While reset is high, and in the cycle after it falls, addrValid, lastFrame and walkDone are 0 and frameType, frameMajor and frameMinor are all 0. This also holds when reset arrives in the middle of a walk.
- R2: In the idle state, a startReq pulse makes addrValid 1 on the next cycle with the address (type 0, major 0, minor 0).
- R3: While addrValid is 1 and addrReady is 0, the address and addrValid stay unchanged.
- R4: Type 0 has LOGIC_COLS+5 majors. frameCount is 4 at majors 0, 1 and LOGIC_COLS+4, and 22 at every other type 0 major.
- R5: Type 1 has MEM_COLS majors, and frameCount is 64 at each of them.
- R6: Type 2 has MEM_COLS majors, and frameCount is 22 at each of them.
- R7: Each accepted address moves the minor up by one within a column. After the minor frameCount-1, the next address is minor 0 of the next major. After the last major of a type, the next address is major 0, minor 0 of the next type, following the order 0, 1, 2.
- R8: lastFrame is 1 only while addrValid is 1 and the address is (type 2, major MEM_COLS-1, minor 21).
- R9: On the cycle after the lastFrame address is accepted, walkDone is 1 for exactly one cycle, addrValid is 0 and the address is back at zero.
- R10: A startReq that arrives while a walk is running has no effect on the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Starts a walk when the block is idle |
| addrReady | input | 1 | Consumer accepts the current address |
| addrValid | output | 1 | Current address is valid |
| frameType | output | 2 | Frame type: 0 main, 1 block-memory data, 2 block-memory routing |
| frameMajor | output | MAJOR_W | Column number within the current type |
| frameMinor | output | 6 | Frame number within the current column |
| frameCount | output | 7 | Number of frames in the current column |
| lastFrame | output | 1 | Current address is the final one of the walk |
| walkDone | output | 1 | One-cycle pulse after the final address is accepted |

## Verification
The bench runs the full walk twice. In the first walk ready is held high, so every column boundary and every type boundary is crossed back to back. This separates a wrong per-column frame limit from a wrong major ordering. In the second walk ready drops on every third cycle and start is pulsed repeatedly. An address that moves without a handshake fails the hold checks, and a walk that restarts breaks the expected sequence. Directed cases cover the reset values, a reset in the middle of a walk, and the done pulse with the address returning to zero.

// File: rtl/fas_pkg.sv
package fas_pkg;
  localparam int SPINE_FRAMES   = 4;
  localparam int IOB_FRAMES     = 4;
  localparam int IOI_FRAMES     = 22;
  localparam int LOGIC_FRAMES   = 22;
  localparam int MEMDATA_FRAMES = 64;
  localparam int MEMINT_FRAMES  = 22;
  localparam int MINOR_W        = $clog2(MEMDATA_FRAMES);
  localparam int COUNT_W        = MINOR_W + 1;

  typedef enum logic [1:0] {
    FT_MAIN    = 2'd0,
    FT_MEMDATA = 2'd1,
    FT_MEMINT  = 2'd2
  } frameType_e;

  typedef struct packed {
    logic clearAddr;
    logic stepMinor;
    logic stepMajor;
    logic stepType;
  } seqStrobe_t;
endpackage

// File: rtl/fas_datapath.sv
module fas_datapath
  import fas_pkg::*;
#(
  parameter int LOGIC_COLS = 8,
  parameter int MEM_COLS   = 2,
  parameter int MAJOR_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strobe,
  output logic [1:0]         frameType,
  output logic [MAJOR_W-1:0] frameMajor,
  output logic [MINOR_W-1:0] frameMinor,
  output logic [COUNT_W-1:0] frameCount,
  output logic               colEnd,
  output logic               typeEnd,
  output logic               walkEnd
);
  localparam logic [MAJOR_W-1:0] MAIN_LAST = MAJOR_W'(LOGIC_COLS + 4);
  localparam logic [MAJOR_W-1:0] MEM_LAST  = MAJOR_W'(MEM_COLS - 1);

  logic [1:0]         typeQ;
  logic [MAJOR_W-1:0] majorQ;
  logic [MINOR_W-1:0] minorQ;
  logic [COUNT_W-1:0] colFrames;
  logic [MAJOR_W-1:0] lastMajor;

  // frame limit of the current column, chosen by column kind
  always_comb begin
    colFrames = COUNT_W'(MEMINT_FRAMES);
    lastMajor = MEM_LAST;
    case (typeQ)
      FT_MAIN: begin
        lastMajor = MAIN_LAST;
        if (majorQ == '0)
          colFrames = COUNT_W'(SPINE_FRAMES);
        else if (majorQ == MAJOR_W'(1) || majorQ == MAIN_LAST)
          colFrames = COUNT_W'(IOB_FRAMES);
        else if (majorQ == MAJOR_W'(2) || majorQ == MAJOR_W'(LOGIC_COLS + 3))
          colFrames = COUNT_W'(IOI_FRAMES);
        else
          colFrames = COUNT_W'(LOGIC_FRAMES);
      end
      FT_MEMDATA: colFrames = COUNT_W'(MEMDATA_FRAMES);
      default:    colFrames = COUNT_W'(MEMINT_FRAMES);
    endcase
  end

  assign colEnd  = ({1'b0, minorQ} == colFrames - COUNT_W'(1));
  assign typeEnd = (majorQ == lastMajor);
  assign walkEnd = colEnd && typeEnd && (typeQ == FT_MEMINT);

  always_ff @(posedge clk) begin
    if (rst || strobe.clearAddr) begin
      typeQ  <= '0;
      majorQ <= '0;
      minorQ <= '0;
    end else if (strobe.stepType) begin
      typeQ  <= typeQ + 2'd1;
      majorQ <= '0;
      minorQ <= '0;
    end else if (strobe.stepMajor) begin
      majorQ <= majorQ + MAJOR_W'(1);
      minorQ <= '0;
    end else if (strobe.stepMinor) begin
      minorQ <= minorQ + MINOR_W'(1);
    end
  end

  assign frameType  = typeQ;
  assign frameMajor = majorQ;
  assign frameMinor = minorQ;
  assign frameCount = colFrames;
endmodule

// File: rtl/fas_ctrl.sv
module fas_ctrl
  import fas_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       addrReady,
  input  logic       colEnd,
  input  logic       typeEnd,
  input  logic       walkEnd,
  output seqStrobe_t strobe,
  output logic       addrValid,
  output logic       lastFrame,
  output logic       walkDone
);
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_e;

  ctrlState_e stateQ;
  logic       doneQ;
  logic       fire;

  assign fire      = (stateQ == ST_RUN) && addrReady;
  assign addrValid = (stateQ == ST_RUN);
  assign lastFrame = (stateQ == ST_RUN) && walkEnd;
  assign walkDone  = doneQ;

  always_comb begin
    strobe.clearAddr = ((stateQ == ST_IDLE) && startReq) || (fire && walkEnd);
    strobe.stepMinor = fire && !colEnd;
    strobe.stepMajor = fire && colEnd && !typeEnd;
    strobe.stepType  = fire && colEnd && typeEnd && !walkEnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= fire && walkEnd;
      if (stateQ == ST_IDLE && startReq)
        stateQ <= ST_RUN;
      else if (fire && walkEnd)
        stateQ <= ST_IDLE;
    end
  end
endmodule

// File: rtl/frame_addr_seq.sv
module frame_addr_seq
  import fas_pkg::*;
#(
  parameter int LOGIC_COLS = 8,
  parameter int MEM_COLS   = 2,
  localparam int MAX_MAJOR = (LOGIC_COLS + 4 > MEM_COLS - 1) ? LOGIC_COLS + 4 : MEM_COLS - 1,
  localparam int MAJOR_W   = $clog2(MAX_MAJOR + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startReq,
  input  logic               addrReady,
  output logic               addrValid,
  output logic [1:0]         frameType,
  output logic [MAJOR_W-1:0] frameMajor,
  output logic [5:0]         frameMinor,
  output logic [6:0]         frameCount,
  output logic               lastFrame,
  output logic               walkDone
);
  seqStrobe_t strobe;
  logic colEnd, typeEnd, walkEnd;

  fas_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .addrReady(addrReady),
    .colEnd(colEnd), .typeEnd(typeEnd), .walkEnd(walkEnd),
    .strobe(strobe), .addrValid(addrValid), .lastFrame(lastFrame),
    .walkDone(walkDone)
  );

  fas_datapath #(.LOGIC_COLS(LOGIC_COLS), .MEM_COLS(MEM_COLS), .MAJOR_W(MAJOR_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .frameType(frameType), .frameMajor(frameMajor), .frameMinor(frameMinor),
    .frameCount(frameCount), .colEnd(colEnd), .typeEnd(typeEnd), .walkEnd(walkEnd)
  );
endmodule

// File: rtl/frame_addr_seq_chk.sv
module frame_addr_seq_chk #(
  parameter int LOGIC_COLS = 8,
  parameter int MEM_COLS   = 2,
  localparam int MAX_MAJOR = (LOGIC_COLS + 4 > MEM_COLS - 1) ? LOGIC_COLS + 4 : MEM_COLS - 1,
  localparam int MAJOR_W   = $clog2(MAX_MAJOR + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               startReq,
  input logic               addrReady,
  input logic               addrValid,
  input logic [1:0]         frameType,
  input logic [MAJOR_W-1:0] frameMajor,
  input logic [5:0]         frameMinor,
  input logic [6:0]         frameCount,
  input logic               lastFrame,
  input logic               walkDone
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !addrValid && !walkDone && frameType == 2'd0 && frameMajor == '0 && frameMinor == '0); // R1
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    !addrValid && startReq |=> addrValid && frameType == 2'd0 && frameMajor == '0 && frameMinor == '0); // R2
  AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (rst)
    addrValid && !addrReady |=> addrValid && $stable(frameType) && $stable(frameMajor) && $stable(frameMinor)); // R3
  AST_IOB_SPINE_COUNT: assert property (@(posedge clk) disable iff (rst)
    addrValid && frameType == 2'd0 && (frameMajor < MAJOR_W'(2) || frameMajor == MAJOR_W'(LOGIC_COLS + 4)) |-> frameCount == 7'd4); // R4
  AST_MINOR_BOUND: assert property (@(posedge clk) disable iff (rst)
    addrValid |-> {1'b0, frameMinor} < frameCount); // R4
  AST_MINOR_STEP: assert property (@(posedge clk) disable iff (rst)
    addrValid && addrReady && ({1'b0, frameMinor} != frameCount - 7'd1)
      |=> frameMinor == $past(frameMinor) + 6'd1 && $stable(frameMajor) && $stable(frameType)); // R7
  AST_LAST_ADDR: assert property (@(posedge clk) disable iff (rst)
    lastFrame |-> addrValid && frameType == 2'd2 && frameMajor == MAJOR_W'(MEM_COLS - 1) && frameMinor == 6'd21); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    addrValid && addrReady && lastFrame |=> walkDone && !addrValid && frameMinor == '0); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    walkDone |=> !walkDone); // R9
endmodule

bind frame_addr_seq frame_addr_seq_chk #(.LOGIC_COLS(LOGIC_COLS), .MEM_COLS(MEM_COLS)) u_chk (.*);

// File: tb/frame_addr_seq_tb.sv
`timescale 1ns/1ps
module frame_addr_seq_tb;
  localparam int L = 8;
  localparam int M = 2;
  localparam int NROWS = L + 5 + 2 * M;

  typedef struct packed {
    logic [1:0] ft;
    logic [3:0] maj;
    logic [6:0] cnt;
  } colRow_t;

  // expected column walk: type, major, frames in column
  localparam colRow_t COLS [NROWS] = '{
    '{2'd0, 4'd0, 7'd4},  '{2'd0, 4'd1, 7'd4},  '{2'd0, 4'd2, 7'd22},
    '{2'd0, 4'd3, 7'd22}, '{2'd0, 4'd4, 7'd22}, '{2'd0, 4'd5, 7'd22},
    '{2'd0, 4'd6, 7'd22}, '{2'd0, 4'd7, 7'd22}, '{2'd0, 4'd8, 7'd22},
    '{2'd0, 4'd9, 7'd22}, '{2'd0, 4'd10, 7'd22}, '{2'd0, 4'd11, 7'd22},
    '{2'd0, 4'd12, 7'd4}, '{2'd1, 4'd0, 7'd64}, '{2'd1, 4'd1, 7'd64},
    '{2'd2, 4'd0, 7'd22}, '{2'd2, 4'd1, 7'd22}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic addrReady = 1'b0;
  logic addrValid, lastFrame, walkDone;
  logic [1:0] frameType;
  logic [3:0] frameMajor;
  logic [5:0] frameMinor;
  logic [6:0] frameCount;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  frame_addr_seq #(.LOGIC_COLS(L), .MEM_COLS(M)) u_dut (
    .clk(clk), .rst(rst), .startReq(startReq), .addrReady(addrReady),
    .addrValid(addrValid), .frameType(frameType), .frameMajor(frameMajor),
    .frameMinor(frameMinor), .frameCount(frameCount), .lastFrame(lastFrame),
    .walkDone(walkDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkIdleZero(input string req);
    chk({req, " valid"}, int'(addrValid), 0);
    chk({req, " type"}, int'(frameType), 0);
    chk({req, " major"}, int'(frameMajor), 0);
    chk({req, " minor"}, int'(frameMinor), 0);
    chk({req, " last"}, int'(lastFrame), 0);
  endtask

  // one full walk; mode 1 stalls ready every third cycle and pulses start
  task automatic runWalk(input int mode);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R2 valid after start", int'(addrValid), 1);
    for (int r = 0; r < NROWS; r++) begin
      for (int mi = 0; mi < int'(COLS[r].cnt); mi++) begin
        bit taken = 1'b0;
        while (!taken) begin
          cyc++;
          addrReady = (mode == 0) ? 1'b1 : (cyc % 3 != 2);
          if (mode == 1) startReq = (cyc % 5 == 0); // R10 start mid-walk
          chk("R4/R5/R6 valid", int'(addrValid), 1);
          chk("R7 type", int'(frameType), int'(COLS[r].ft));
          chk("R7 major", int'(frameMajor), int'(COLS[r].maj));
          chk("R7 minor", int'(frameMinor), mi);
          chk("R4/R5/R6 count", int'(frameCount), int'(COLS[r].cnt));
          chk("R8 last", int'(lastFrame),
              int'(r == NROWS - 1 && mi == int'(COLS[r].cnt) - 1));
          if (!addrReady) chk("R3 held under stall", int'(addrValid), 1);
          taken = addrReady;
          @(negedge clk);
        end
      end
    end
    startReq = 1'b0;
    addrReady = 1'b0;
    chk("R9 done pulse", int'(walkDone), 1);
    chkIdleZero("R9 after done");
    @(negedge clk);
    chk("R9 done single cycle", int'(walkDone), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdleZero("R1 in reset");
    chk("R1 done in reset", int'(walkDone), 0);
    rst = 1'b0;
    @(negedge clk);
    chkIdleZero("R1 after reset");
    addrReady = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 no start stays idle", int'(addrValid), 0);
    addrReady = 1'b0;

    runWalk(0);
    runWalk(1);

    // R1: reset in the middle of a walk
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    addrReady = 1'b1;
    repeat (7) @(negedge clk);
    chk("R7 minor before mid reset", int'(frameMinor), 3);
    chk("R7 major before mid reset", int'(frameMajor), 1);
    rst = 1'b1;
    addrReady = 1'b0;
    @(negedge clk);
    chkIdleZero("R1 mid-walk reset");
    rst = 1'b0;
    @(negedge clk);
    chkIdleZero("R1 after mid-walk reset");
    chk("R1 no done after reset", int'(walkDone), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule